// File: doc/BRIEF.md
# Windowed Monobit and Poker Health Tester

This block watches a serial stream of random bits and judges its quality in fixed windows of `WINDOW_BITS` accepted bits (20,000 by default). A bit is taken on each clock where `bit_valid` is high. Within a window it keeps a running count of ones for a monobit test. It also splits the stream into non-overlapping 4-bit symbols, aligned to the start of the window with the earliest bit as the symbol's top bit, and keeps one occurrence counter for each of the 16 symbol values for a poker test.

When the last bit of a window is taken, both tests are judged on the final counts. Each failing test raises its own output for exactly one clock, one cycle after that last bit. All counters clear at the same edge and the next window begins with the next accepted bit. The poker judgement checks every symbol counter against a per-symbol range. It also checks sixteen times the sum of the squared symbol counts against an exclusive integer range. With 5,000 symbols per window, the default bounds correspond to the usual statistic of 16/5000 times the sum minus 5000 lying strictly between 1.03 and 57.4.

A synchronous `clr` discards the partial window and starts a fresh one.

Top module: `health_tester`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `mono_fail` and `poker_fail` are low, and the first window starts with the first accepted bit after reset.
- R2: Judgement happens only after exactly `WINDOW_BITS` accepted bits. A fail output is high only in the single cycle that follows the last bit of a window, and counting restarts from zero for the next bit.
- R3: `mono_fail` pulses when the ones count of the window is not strictly between `MONO_LO` and `MONO_HI` (defaults 9654 and 10346).
- R4: Symbols are consecutive non-overlapping groups of 4 accepted bits, aligned to the first bit of the window, with the earliest bit as bit 3 of the symbol. There are `WINDOW_BITS`/4 symbols per window.
- R5: `poker_fail` pulses when any of the 16 symbol counts is above `CELL_MAX` or below `CELL_MIN`.
- R6: `poker_fail` pulses when 16 times the sum of the squared symbol counts is not strictly between `SQ16_LO` and `SQ16_HI` (defaults 25005150 and 25287000).
- R7: A cycle with `bit_valid` low changes no count, whatever `bit_in` holds.
- R8: `clr` high empties the window and all counters, and no fail pulse results from the bits discarded.
- R9: When `clr` is high in the same cycle as the bit that would close a window, the clear wins: that bit is dropped, and no fail pulse follows.
- R10: Windows sent back to back with no idle cycle are judged independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart of the current window |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Stream bit |
| mono_fail | output | 1 | One-cycle pulse: monobit test failed for the window just closed |
| poker_fail | output | 1 | One-cycle pulse: poker test failed for the window just closed |

## Verification
Two of the block's functions can land in the same cycle: the closing of a window by its last bit, and the restart requested by `clr`. The bench drives the bit that completes a window that would fail both tests together with `clr` high. It then requires both outputs to stay low in the following cycle and the next full window to be judged from a clean start. The bench also lets the monobit and poker judgements fall on the same edge across a sweep of thousands of back-to-back pseudo-random windows on a 16-bit configuration. Both outputs are compared every cycle against counts that the bench rebuilds arithmetically from the bits it sent.

// File: rtl/hth_pkg.sv
package hth_pkg;
  localparam int SYM_BITS  = 4;
  localparam int SYM_COUNT = 1 << SYM_BITS;
  localparam int PH_W      = $clog2(SYM_BITS);
  typedef logic [SYM_BITS-1:0] sym_t;
endpackage

// File: rtl/hth_window_ctrl.sv
// Bit position within the window, symbol assembly and window-close strobe.
module hth_window_ctrl
  import hth_pkg::*;
#(
  parameter int WINDOW_BITS = 20000,
  parameter int IDX_W       = $clog2(WINDOW_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic             take,
  output logic             last,
  output logic             sym_valid,
  output sym_t             sym,
  output logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW_BITS - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(SYM_BITS - 1);

  logic [IDX_W-1:0]    idx_q;
  logic [SYM_BITS-2:0] part_q;

  // clear has priority over an incoming bit
  assign take      = bit_valid & ~clr;
  assign last      = take & (idx_q == LAST_IDX);
  assign sym_valid = take & (idx_q[PH_W-1:0] == PH_LAST);
  assign sym       = {part_q, bit_in};
  assign bit_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q  <= '0;
      part_q <= '0;
    end else if (take) begin
      idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      part_q <= {part_q[SYM_BITS-3:0], bit_in};
    end
  end
endmodule

// File: rtl/hth_monobit.sv
// Ones counter and monobit judgement.
module hth_monobit #(
  parameter int WINDOW_BITS = 20000,
  parameter int MONO_LO     = 9654,
  parameter int MONO_HI     = 10346
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic take,
  input  logic last,
  input  logic bit_in,
  output logic fail
);
  localparam int CW = $clog2(WINDOW_BITS + 1);

  logic [CW-1:0] ones_q;
  logic [CW-1:0] ones_nx;
  logic          in_range;

  always_comb begin
    ones_nx  = ones_q + CW'(take & bit_in);
    in_range = (int'(ones_nx) > MONO_LO) && (int'(ones_nx) < MONO_HI);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q <= '0;
      fail   <= 1'b0;
    end else begin
      fail <= last & ~in_range;
      if (last)      ones_q <= '0;
      else if (take) ones_q <= ones_nx;
    end
  end
endmodule

// File: rtl/hth_poker.sv
// Symbol occurrence counters, running sum of squares and poker judgement.
module hth_poker
  import hth_pkg::*;
#(
  parameter int NIBBLES  = 5000,
  parameter int CELL_MIN = 240,
  parameter int CELL_MAX = 390,
  parameter int SQ16_LO  = 25005150,
  parameter int SQ16_HI  = 25287000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sym_valid,
  input  sym_t sym,
  input  logic last,
  output logic fail
);
  localparam int CW = $clog2(NIBBLES + 1);
  localparam int SW = $clog2(NIBBLES * NIBBLES + 1);

  logic [CW-1:0]     cnt_q  [SYM_COUNT];
  logic [CW-1:0]     cnt_nx [SYM_COUNT];
  logic [SYM_COUNT-1:0] cell_bad;
  logic [CW-1:0]     sel_cnt;
  logic [SW-1:0]     sq_q;
  logic [SW-1:0]     sq_nx;
  logic [SW+3:0]     sq16;
  logic              sq_ok;

  // (n+1)^2 - n^2 = 2n+1: the sum of squares follows each increment
  always_comb begin
    sel_cnt = cnt_q[sym];
    sq_nx   = sq_q + (sym_valid ? SW'({sel_cnt, 1'b1}) : '0);
    sq16    = {sq_nx, 4'b0000};
    sq_ok   = (int'(sq16) > SQ16_LO) && (int'(sq16) < SQ16_HI);
  end

  for (genvar i = 0; i < SYM_COUNT; i++) begin : g_cell
    always_comb begin
      cnt_nx[i]   = cnt_q[i] + CW'(sym_valid && (sym == sym_t'(i)));
      cell_bad[i] = (int'(cnt_nx[i]) > CELL_MAX) || (int'(cnt_nx[i]) < CELL_MIN);
    end
    always_ff @(posedge clk) begin
      if (rst || clr || last) cnt_q[i] <= '0;
      else                    cnt_q[i] <= cnt_nx[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sq_q <= '0;
      fail <= 1'b0;
    end else begin
      fail <= last & ((|cell_bad) | ~sq_ok);
      sq_q <= last ? '0 : sq_nx;
    end
  end
endmodule

// File: rtl/health_tester.sv
module health_tester
  import hth_pkg::*;
#(
  parameter int WINDOW_BITS = 20000,
  parameter int MONO_LO     = 9654,
  parameter int MONO_HI     = 10346,
  parameter int CELL_MIN    = 240,
  parameter int CELL_MAX    = 390,
  parameter int SQ16_LO     = 25005150,
  parameter int SQ16_HI     = 25287000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_valid,
  input  logic bit_in,
  output logic mono_fail,
  output logic poker_fail
);
  localparam int IDX_W   = $clog2(WINDOW_BITS);
  localparam int NIBBLES = WINDOW_BITS / SYM_BITS;

  logic             take;
  logic             last;
  logic             sym_valid;
  sym_t             sym;
  logic [IDX_W-1:0] bit_idx;

  hth_window_ctrl #(
    .WINDOW_BITS(WINDOW_BITS),
    .IDX_W      (IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .bit_valid(bit_valid),
    .bit_in   (bit_in),
    .take     (take),
    .last     (last),
    .sym_valid(sym_valid),
    .sym      (sym),
    .bit_idx  (bit_idx)
  );

  hth_monobit #(
    .WINDOW_BITS(WINDOW_BITS),
    .MONO_LO    (MONO_LO),
    .MONO_HI    (MONO_HI)
  ) u_mono (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .take  (take),
    .last  (last),
    .bit_in(bit_in),
    .fail  (mono_fail)
  );

  hth_poker #(
    .NIBBLES (NIBBLES),
    .CELL_MIN(CELL_MIN),
    .CELL_MAX(CELL_MAX),
    .SQ16_LO (SQ16_LO),
    .SQ16_HI (SQ16_HI)
  ) u_poker (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .sym_valid(sym_valid),
    .sym      (sym),
    .last     (last),
    .fail     (poker_fail)
  );
endmodule

// File: rtl/hth_checker.sv
module hth_checker #(
  parameter int WINDOW_BITS = 20000,
  parameter int IDX_W       = $clog2(WINDOW_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             bit_valid,
  input logic             mono_fail,
  input logic             poker_fail,
  input logic [IDX_W-1:0] bit_idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WINDOW_BITS - 1);

  AST_MONO_SINGLE: assert property (@(posedge clk) disable iff (rst) mono_fail |=> !mono_fail); // R2
  AST_POKER_SINGLE: assert property (@(posedge clk) disable iff (rst) poker_fail |=> !poker_fail); // R2
  AST_PULSE_AFTER_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (mono_fail || poker_fail) |-> $past(bit_valid && !clr && bit_idx == LAST_IDX)); // R2
  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) bit_idx <= LAST_IDX); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !clr) |=> $stable(bit_idx)); // R7
  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!mono_fail && !poker_fail && bit_idx == '0)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!mono_fail && !poker_fail)); // R1
endmodule

bind health_tester hth_checker #(
  .WINDOW_BITS(WINDOW_BITS),
  .IDX_W      (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .bit_valid (bit_valid),
  .mono_fail (mono_fail),
  .poker_fail(poker_fail),
  .bit_idx   (bit_idx)
);

// File: tb/sim_health_tester.sv
`timescale 1ns/1ps
module sim_health_tester;
  localparam int WB       = 16;
  localparam int MONO_LO  = 5;
  localparam int MONO_HI  = 11;
  localparam int CELL_MIN = 0;
  localparam int CELL_MAX = 2;
  localparam int SQ16_LO  = 64;
  localparam int SQ16_HI  = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic mono_fail;
  logic poker_fail;

  always #4 clk = ~clk;

  health_tester #(
    .WINDOW_BITS(WB), .MONO_LO(MONO_LO), .MONO_HI(MONO_HI),
    .CELL_MIN(CELL_MIN), .CELL_MAX(CELL_MAX), .SQ16_LO(SQ16_LO), .SQ16_HI(SQ16_HI)
  ) u0 (
    .clk(clk), .rst(rst), .clr(clr), .bit_valid(bit_valid), .bit_in(bit_in),
    .mono_fail(mono_fail), .poker_fail(poker_fail)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  bit    exp_m = 1'b0;
  bit    exp_p = 1'b0;
  string prev_tag = "R1";
  int    m_idx;
  int    m_ones;
  int    m_cnt [16];
  logic [3:0] m_sh;

  function automatic void model_clear();
    m_idx  = 0;
    m_ones = 0;
    m_sh   = 4'h0;
    foreach (m_cnt[k]) m_cnt[k] = 0;
  endfunction

  // judgement computed from the requirements: R3, R5, R6
  function automatic void model_judge();
    int  s = 0;
    bit  cell_bad = 1'b0;
    foreach (m_cnt[k]) begin
      s += m_cnt[k] * m_cnt[k];
      if (m_cnt[k] > CELL_MAX || m_cnt[k] < CELL_MIN) cell_bad = 1'b1;
    end
    exp_m = !(m_ones > MONO_LO && m_ones < MONO_HI);
    exp_p = cell_bad || !(16 * s > SQ16_LO && 16 * s < SQ16_HI);
  endfunction

  task automatic check_outputs();
    n_chk += 2;
    if (mono_fail !== exp_m) begin
      n_bad++;
      $display("FAIL %s mono_fail actual %b expected %b at %0t", prev_tag, mono_fail, exp_m, $time);
    end
    if (poker_fail !== exp_p) begin
      n_bad++;
      $display("FAIL %s poker_fail actual %b expected %b at %0t", prev_tag, poker_fail, exp_p, $time);
    end
  endtask

  // one cycle: check what the previous cycle produced, then drive new inputs
  task automatic step(input bit v, input bit b, input bit c, input string tag);
    @(negedge clk);
    check_outputs();
    bit_valid = v;
    bit_in    = b;
    clr       = c;
    prev_tag  = tag;
    exp_m     = 1'b0;
    exp_p     = 1'b0;
    if (c) begin
      model_clear();
    end else if (v) begin
      m_ones += int'(b);
      m_sh    = {m_sh[2:0], b};
      if (m_idx % 4 == 3) m_cnt[m_sh]++;
      m_idx++;
      if (m_idx == WB) begin
        model_judge();
        model_clear();
      end
    end
  endtask

  task automatic send_word(input logic [15:0] w, input string tag);
    for (int i = 15; i >= 0; i--) step(1'b1, w[i], 1'b0, tag);
  endtask

  initial begin
    logic [31:0] x;
    model_clear();
    repeat (3) @(negedge clk);
    n_chk += 2;
    if (mono_fail !== 1'b0 || poker_fail !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 outputs in reset actual %b%b expected 00", mono_fail, poker_fail);
    end
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, "R1");

    // R4: aligned symbols 0,F,F,0 and 3,C,3,C both pass
    send_word(16'h0FF0, "R4");
    send_word(16'h3C3C, "R4");
    // R5: symbol 0 three times exceeds the cell limit
    send_word(16'h000F, "R5");
    send_word(16'hF0F1, "R5");
    // R6: four distinct symbols give a sum of squares at the lower bound
    send_word(16'h0123, "R6");
    send_word(16'h5AA5, "R6");
    // R3 boundaries: 5 and 11 ones fail, 6 and 10 pass
    send_word(16'h1F00, "R3");
    send_word(16'h3F00, "R3");
    send_word(16'h3FF0, "R3");
    send_word(16'h7FF0, "R3");

    // R7: idle cycles with a toggling bit between real bits
    for (int i = 15; i >= 0; i--) begin
      step(1'b0, i[0], 1'b0, "R7");
      step(1'b1, 16'h6996 >> i, 1'b0, "R7");
    end
    for (int i = 15; i >= 0; i--) begin
      step(1'b0, ~i[0], 1'b0, "R7");
      step(1'b1, 16'h0F0F >> i, 1'b0, "R7");
    end

    // R8: partial window of ones discarded by clear
    for (int i = 0; i < 7; i++) step(1'b1, 1'b1, 1'b0, "R8");
    step(1'b1, 1'b1, 1'b1, "R8");
    send_word(16'h3C5A, "R8");

    // R9: clear coincides with the bit that would close a failing window
    for (int i = 15; i >= 1; i--) step(1'b1, 1'b0, 1'b0, "R9");
    step(1'b1, 1'b0, 1'b1, "R9");
    step(1'b0, 1'b0, 1'b0, "R9");
    send_word(16'h96C3, "R9");

    // R10: back-to-back pseudo-random windows
    x = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      x = x * 32'd1103515245 + 32'd12345;
      send_word(x[30:15], "R3 R5 R6 R10");
    end

    step(1'b0, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b0, 1'b0, "R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule